// File: doc/BRIEF.md
# Memory-Mapped Serial Port Controller

This block is a register-mapped asynchronous serial port. A host reaches it through a simple 32-bit register bus. Each direction holds exactly one byte. The transmitter frames the held byte onto `txd`. The receiver watches `rxd`, rebuilds bytes from it and parks each byte in a one-byte receive buffer until the host reads it.

The frame is fixed: one low start bit, then eight data bits with the least significant bit first, then one high stop bit. There is no parity. A 21-bit divider sets how many clock cycles each bit lasts, and software keeps it at 16 or above. Four sticky event flags record these events: a byte leaving the TX buffer, a byte landing in the RX buffer, a TX overrun and an RX overrun. Software clears a flag by writing one to it. Three interrupt lines carry the flags, each gated by its own enable bit. TX and RX each have their own line, and the two overrun events share the third.

The register bus is a plain request port, not a stream. A request lasts one cycle. A write takes effect at that cycle's clock edge. Read data is registered and appears on `bus_rdata` in the next cycle. The port never stalls.

Top module: `serial_port_ctl`

## Requirements
- R1: The register word is selected by `bus_addr[4:2]`: data at 0x00, status at 0x04, control at 0x08, event flags at 0x0C and bit-period divider at 0x10. Read data appears on `bus_rdata` one cycle after the read request. Bits with no function read as zero, so control is 6 bits wide and the divider is 21 bits wide.
- R2: The status word carries these bits: bit 0 TX buffer full, bit 1 RX buffer full, bit 2 TX overrun, bit 3 RX overrun. The flag word uses the same bit layout for its four flags: bit 0 TX, bit 1 RX, bit 2 TX overrun, bit 3 RX overrun.
- R3: After reset, `txd` is high and all interrupt lines are low. Status, control and flags read 0, and the divider reads 16.
- R4: The held byte moves into the shifter at the first clock edge at which TX is enabled (control bit 0), the shifter is idle and a byte is held. At that edge TX-full drops. From the next cycle, `txd` sends the start bit, the eight data bits LSB first and the stop bit, each lasting divider-many cycles. A back-to-back frame starts after one idle-high cycle.
- R5: The TX flag is set at the edge where the byte moves into the shifter. `tx_irq` is this flag ANDed with control bit 2.
- R6: A data write while TX-full is set discards the byte and sets the TX overrun flag.
- R7: While RX is enabled (control bit 1), a falling edge on the synchronised `rxd` starts a frame. Each bit is sampled at its midpoint. At the midpoint of the stop bit, the byte is loaded into the RX buffer, and RX-full and the RX flag are set. `rx_irq` is the RX flag ANDed with control bit 3.
- R8: A low pulse that has ended by the midpoint of the start bit is discarded, and no byte is loaded.
- R9: While RX is disabled, frames on `rxd` are ignored.
- R10: Reading the data word returns the buffered byte and clears RX-full. A byte that completes while RX-full is still set sets the RX overrun flag, and the buffered byte is kept.
- R11: Writing one to a bit of the flag word clears that flag. `ovr_irq` is high when the TX overrun flag is set with control bit 4, or when the RX overrun flag is set with control bit 5.
- R12: While TX is disabled, a held byte stays in the buffer, TX-full stays set and `txd` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register request this cycle |
| bus_wen | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| txd | output | 1 | Serial output, idles high |
| rxd | input | 1 | Serial input, asynchronous |
| tx_irq | output | 1 | TX buffer-emptied interrupt |
| rx_irq | output | 1 | RX byte-received interrupt |
| ovr_irq | output | 1 | Combined overrun interrupt |

## Verification
Read data is due one cycle after the read request. The bench's read task therefore drives the request on a falling edge and samples `bus_rdata` on the next falling edge. A data write registers at its edge, the byte enters the shifter one edge later, and the start bit appears on `txd` the cycle after that. A behavioural model built on that count predicts `txd` and `tx_irq` and is compared against them at every falling edge. A received byte lands about two synchroniser stages plus half a bit period after the stop bit begins, so the bench waits a few cycles after each sent frame before it reads the status word.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam int ADDR_W    = 5;
  localparam int DATA_BITS = 8;
  localparam int FRAME_LEN = DATA_BITS + 2;

  // word index = bus_addr[4:2]
  localparam logic [2:0] W_DATA  = 3'd0;
  localparam logic [2:0] W_STAT  = 3'd1;
  localparam logic [2:0] W_CTRL  = 3'd2;
  localparam logic [2:0] W_FLAG  = 3'd3;
  localparam logic [2:0] W_DIV   = 3'd4;

  // control bits
  localparam int C_TX_ON   = 0;
  localparam int C_RX_ON   = 1;
  localparam int C_TX_IE   = 2;
  localparam int C_RX_IE   = 3;
  localparam int C_TXO_IE  = 4;
  localparam int C_RXO_IE  = 5;
  localparam int CTRL_W    = 6;

  // flag bits (status uses the same positions for the overrun pair)
  localparam int F_TX  = 0;
  localparam int F_RX  = 1;
  localparam int F_TXO = 2;
  localparam int F_RXO = 3;
  localparam int FLAG_W = 4;

  typedef enum logic [1:0] {RXS_IDLE, RXS_START, RXS_BITS, RXS_STOP} rx_state_t;
endpackage

// File: rtl/ser_tx.sv
module ser_tx import ser_pkg::*; #(
  parameter int DIV_W = 21
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIV_W-1:0]     div,
  input  logic                 load,
  input  logic [DATA_BITS-1:0] load_byte,
  output logic                 busy,
  output logic                 txd
);
  localparam int CNT_W = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] FRAME_CNT = CNT_W'(FRAME_LEN);

  logic [FRAME_LEN-1:0] shift_q;
  logic [CNT_W-1:0]     left_q;
  logic [DIV_W-1:0]     tick_q;

  assign busy = (left_q != '0);
  assign txd  = busy ? shift_q[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '1;
      left_q  <= '0;
      tick_q  <= '0;
    end else if (load) begin
      shift_q <= {1'b1, load_byte, 1'b0};
      left_q  <= FRAME_CNT;
      tick_q  <= div - 1'b1;
    end else if (busy) begin
      if (tick_q == '0) begin
        shift_q <= {1'b1, shift_q[FRAME_LEN-1:1]};
        left_q  <= left_q - 1'b1;
        tick_q  <= div - 1'b1;
      end else begin
        tick_q  <= tick_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/ser_rx.sv
module ser_rx import ser_pkg::*; #(
  parameter int DIV_W = 21,
  parameter int SYNC  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic [DIV_W-1:0]     div,
  input  logic                 rxd,
  output logic                 byte_valid,
  output logic [DATA_BITS-1:0] byte_out
);
  localparam int IDX_W = $clog2(DATA_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_BITS - 1);

  logic [SYNC-1:0]      sync_q;
  logic                 line, prev_q;
  rx_state_t            st_q;
  logic [DIV_W-1:0]     tick_q;
  logic [IDX_W-1:0]     idx_q;
  logic [DATA_BITS-1:0] sh_q;
  logic                 valid_q;

  assign line       = sync_q[SYNC-1];
  assign byte_valid = valid_q;
  assign byte_out   = sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], rxd};
      prev_q <= line;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RXS_IDLE;
      tick_q  <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      unique case (st_q)
        RXS_IDLE: begin
          if (enable && prev_q && !line) begin
            st_q   <= RXS_START;
            tick_q <= (div >> 1) - 1'b1;
          end
        end
        RXS_START: begin
          if (tick_q == '0) begin
            if (!line) begin
              st_q   <= RXS_BITS;
              tick_q <= div - 1'b1;
              idx_q  <= '0;
            end else begin
              st_q   <= RXS_IDLE;
            end
          end else begin
            tick_q <= tick_q - 1'b1;
          end
        end
        RXS_BITS: begin
          if (tick_q == '0) begin
            sh_q   <= {line, sh_q[DATA_BITS-1:1]};
            tick_q <= div - 1'b1;
            idx_q  <= idx_q + 1'b1;
            if (idx_q == LAST_IDX) st_q <= RXS_STOP;
          end else begin
            tick_q <= tick_q - 1'b1;
          end
        end
        RXS_STOP: begin
          if (tick_q == '0) begin
            valid_q <= 1'b1;
            st_q    <= RXS_IDLE;
          end else begin
            tick_q <= tick_q - 1'b1;
          end
        end
        default: st_q <= RXS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ser_regs.sv
module ser_regs import ser_pkg::*; #(
  parameter int DIV_W = 21,
  parameter int DW    = 32,
  parameter int DIV_RESET = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wen,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  input  logic                 tx_busy,
  output logic                 tx_load,
  output logic [DATA_BITS-1:0] tx_byte,
  input  logic                 rx_valid,
  input  logic [DATA_BITS-1:0] rx_byte,
  output logic [CTRL_W-1:0]    ctrl,
  output logic [DIV_W-1:0]     div,
  output logic [FLAG_W-1:0]    flags,
  output logic                 tx_full,
  output logic                 rx_full,
  output logic                 tx_irq,
  output logic                 rx_irq,
  output logic                 ovr_irq
);
  logic [2:0]           widx;
  logic                 wr, rd, wr_data, rd_data, wr_ctrl, wr_flag, wr_div;
  logic [CTRL_W-1:0]    ctrl_q;
  logic [DIV_W-1:0]     div_q;
  logic [FLAG_W-1:0]    flag_q, flag_set, flag_clr;
  logic                 txf_q, rxf_q, rxf_after_rd;
  logic [DATA_BITS-1:0] txh_q, rxh_q;
  logic [DW-1:0]        rdata_q, rdata_d;
  logic                 unused_bits;

  assign unused_bits = ^{bus_wdata[DW-1:DIV_W], bus_addr[1:0]};

  assign widx    = bus_addr[4:2];
  assign wr      = bus_sel & bus_wen;
  assign rd      = bus_sel & ~bus_wen;
  assign wr_data = wr && (widx == W_DATA);
  assign rd_data = rd && (widx == W_DATA);
  assign wr_ctrl = wr && (widx == W_CTRL);
  assign wr_flag = wr && (widx == W_FLAG);
  assign wr_div  = wr && (widx == W_DIV);

  assign tx_load      = ~tx_busy & txf_q & ctrl_q[C_TX_ON];
  assign rxf_after_rd = rxf_q & ~rd_data;

  always_comb begin
    flag_set         = '0;
    flag_set[F_TX]   = tx_load;
    flag_set[F_RX]   = rx_valid & ~rxf_after_rd;
    flag_set[F_TXO]  = wr_data & txf_q;
    flag_set[F_RXO]  = rx_valid & rxf_after_rd;
    flag_clr         = wr_flag ? bus_wdata[FLAG_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= DIV_W'(DIV_RESET);
      flag_q <= '0;
      txf_q  <= 1'b0;
      txh_q  <= '0;
      rxf_q  <= 1'b0;
      rxh_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
      if (wr_div)  div_q  <= bus_wdata[DIV_W-1:0];
      // a new event wins over a clear in the same cycle
      flag_q <= (flag_q & ~flag_clr) | flag_set;
      if (tx_load) begin
        txf_q <= 1'b0;
      end else if (wr_data && !txf_q) begin
        txf_q <= 1'b1;
        txh_q <= bus_wdata[DATA_BITS-1:0];
      end
      if (rx_valid && !rxf_after_rd) begin
        rxf_q <= 1'b1;
        rxh_q <= rx_byte;
      end else begin
        rxf_q <= rxf_after_rd;
      end
    end
  end

  always_comb begin
    rdata_d = '0;
    unique case (widx)
      W_DATA: rdata_d[DATA_BITS-1:0] = rxh_q;
      W_STAT: rdata_d[3:0] = {flag_q[F_RXO], flag_q[F_TXO], rxf_q, txf_q};
      W_CTRL: rdata_d[CTRL_W-1:0] = ctrl_q;
      W_FLAG: rdata_d[FLAG_W-1:0] = flag_q;
      W_DIV:  rdata_d[DIV_W-1:0] = div_q;
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (rd) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
  assign tx_byte   = txh_q;
  assign ctrl      = ctrl_q;
  assign div       = div_q;
  assign flags     = flag_q;
  assign tx_full   = txf_q;
  assign rx_full   = rxf_q;
  assign tx_irq    = flag_q[F_TX] & ctrl_q[C_TX_IE];
  assign rx_irq    = flag_q[F_RX] & ctrl_q[C_RX_IE];
  assign ovr_irq   = (flag_q[F_TXO] & ctrl_q[C_TXO_IE]) |
                     (flag_q[F_RXO] & ctrl_q[C_RXO_IE]);
endmodule

// File: rtl/serial_port_ctl.sv
module serial_port_ctl import ser_pkg::*; #(
  parameter int DIV_W       = 21,
  parameter int DW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wen,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              txd,
  input  logic              rxd,
  output logic              tx_irq,
  output logic              rx_irq,
  output logic              ovr_irq
);
  localparam int MIN_DIV = 16;

  logic                 tx_busy, tx_load, rx_valid, tx_full, rx_full;
  logic [DATA_BITS-1:0] tx_byte, rx_byte;
  logic [CTRL_W-1:0]    ctrl;
  logic [DIV_W-1:0]     div;
  logic [FLAG_W-1:0]    flags;

  ser_regs #(.DIV_W(DIV_W), .DW(DW), .DIV_RESET(MIN_DIV)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_busy(tx_busy), .tx_load(tx_load), .tx_byte(tx_byte),
    .rx_valid(rx_valid), .rx_byte(rx_byte),
    .ctrl(ctrl), .div(div), .flags(flags),
    .tx_full(tx_full), .rx_full(rx_full),
    .tx_irq(tx_irq), .rx_irq(rx_irq), .ovr_irq(ovr_irq)
  );

  ser_tx #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .div(div),
    .load(tx_load), .load_byte(tx_byte),
    .busy(tx_busy), .txd(txd)
  );

  ser_rx #(.DIV_W(DIV_W), .SYNC(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n), .enable(ctrl[C_RX_ON]), .div(div),
    .rxd(rxd), .byte_valid(rx_valid), .byte_out(rx_byte)
  );
endmodule

// File: rtl/ser_chk.sv
module ser_chk import ser_pkg::*; (
  input logic              clk,
  input logic              rst_n,
  input logic              txd,
  input logic              tx_busy,
  input logic              tx_load,
  input logic              tx_full,
  input logic              rx_full,
  input logic              rx_valid,
  input logic              rx_irq,
  input logic              bus_sel,
  input logic              bus_wen,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [FLAG_W-1:0] flags,
  input logic [CTRL_W-1:0] ctrl
);
  logic wr_dat, rd_dat;
  assign wr_dat = bus_sel &  bus_wen & (bus_addr[4:2] == W_DATA);
  assign rd_dat = bus_sel & ~bus_wen & (bus_addr[4:2] == W_DATA);

  p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);
  p_start_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !txd);
  p_load_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> (!tx_full && flags[F_TX]));
  p_tx_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && tx_full) |=> flags[F_TXO]);
  p_rx_land_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_full) |=> (rx_full && flags[F_RX]));
  p_rx_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[C_RX_IE] |-> !rx_irq);
  p_rx_overrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_full && !rd_dat) |=> (rx_full && flags[F_RXO]));
  p_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && !ctrl[C_TX_ON]) |=> tx_full);
endmodule

bind serial_port_ctl ser_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .tx_busy(tx_busy),
  .tx_load(tx_load), .tx_full(tx_full), .rx_full(rx_full),
  .rx_valid(rx_valid), .rx_irq(rx_irq), .bus_sel(bus_sel),
  .bus_wen(bus_wen), .bus_addr(bus_addr), .flags(flags), .ctrl(ctrl)
);

// File: tb/test_serial_port_ctl.sv
`timescale 1ns/1ps
module test_serial_port_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wen = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        txd, tx_irq, rx_irq, ovr_irq;
  logic        rxd = 1'b1;

  int checks = 0, errors = 0;
  bit mon = 1'b0;

  always #5 clk = ~clk;

  serial_port_ctl i_serial_port_ctl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wen(bus_wen),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .txd(txd), .rxd(rxd), .tx_irq(tx_irq), .rx_irq(rx_irq), .ovr_irq(ovr_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural model of the transmit side
  int       m_div = 16, m_pos = 0;
  bit [5:0] m_ctrl = '0;
  bit       m_full = 0, m_busy = 0, m_txf = 0, m_ld = 0, m_old;
  bit [7:0] m_hold = '0, m_sh = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 16; m_pos = 0; m_ctrl = '0; m_full = 0; m_busy = 0; m_txf = 0;
    end else begin
      m_ld  = !m_busy && m_full && m_ctrl[0];
      m_old = m_full;
      if (m_busy) begin
        if (m_pos == 10*m_div - 1) m_busy = 0;
        else m_pos++;
      end
      if (bus_sel && bus_wen && bus_addr == 5'h0C && bus_wdata[0]) m_txf = 0;
      if (m_ld) begin
        m_busy = 1; m_pos = 0; m_sh = m_hold; m_full = 0; m_txf = 1;
      end
      if (bus_sel && bus_wen && bus_addr == 5'h00 && !m_old) begin
        m_full = 1; m_hold = bus_wdata[7:0];
      end
      if (bus_sel && bus_wen && bus_addr == 5'h08) m_ctrl = bus_wdata[5:0];
      if (bus_sel && bus_wen && bus_addr == 5'h10) m_div = int'(bus_wdata[20:0]);
    end
  end

  function automatic logic exp_txd();
    int b;
    if (!m_busy) return 1'b1;
    b = m_pos / m_div;
    if (b == 0) return 1'b0;
    if (b == 9) return 1'b1;
    return m_sh[b-1];
  endfunction

  always @(negedge clk) begin
    if (mon) begin
      check("R4 txd frame", {31'b0, txd}, {31'b0, exp_txd()});
      check("R5 tx_irq", {31'b0, tx_irq}, {31'b0, m_txf & m_ctrl[2]});
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wen = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wen = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wen = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0; d = bus_rdata;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rxd = 0; repeat (16) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd = b[i]; repeat (16) @(negedge clk); end
    rxd = 1; repeat (16) @(negedge clk);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1;
    mon = 1;
    // R3 reset state
    check("R3 txd", {31'b0, txd}, 32'd1);
    check("R3 irqs", {29'b0, tx_irq, rx_irq, ovr_irq}, 32'd0);
    rd(5'h04, d); check("R3 status", d, 32'h0);
    rd(5'h08, d); check("R3 control", d, 32'h0);
    rd(5'h10, d); check("R3 divider", d, 32'd16);
    rd(5'h0C, d); check("R3 flags", d, 32'h0);
    // R1 decode and unused bits
    wr(5'h08, 32'hFFFF_FFFF); rd(5'h08, d); check("R1 control width", d, 32'h3F);
    wr(5'h10, 32'hFFFF_FFFF); rd(5'h10, d); check("R1 divider width", d, 32'h1F_FFFF);
    wr(5'h10, 32'd16);        rd(5'h10, d); check("R1 divider write", d, 32'd16);
    // R4 R5 R6 transmit, back-to-back and overrun
    wr(5'h00, 32'hA5);
    repeat (20) @(negedge clk);
    wr(5'h00, 32'h3C);
    rd(5'h04, d); check("R2 tx full bit", d & 32'h1, 32'h1);
    wr(5'h00, 32'h77);
    rd(5'h04, d); check("R6 tx overrun status", d & 32'h4, 32'h4);
    check("R11 ovr_irq tx", {31'b0, ovr_irq}, 32'd1);
    repeat (400) @(negedge clk);
    rd(5'h04, d); check("R4 buffer drained", d & 32'h1, 32'h0);
    check("R5 tx_irq set", {31'b0, tx_irq}, 32'd1);
    wr(5'h0C, 32'h5);
    check("R11 tx_irq cleared", {31'b0, tx_irq}, 32'd0);
    check("R11 ovr_irq cleared", {31'b0, ovr_irq}, 32'd0);
    rd(5'h0C, d); check("R11 flags cleared", d & 32'h5, 32'h0);
    // R12 transmit disabled
    wr(5'h08, 32'h3E);
    wr(5'h00, 32'h11);
    repeat (50) @(negedge clk);
    rd(5'h04, d); check("R12 byte held", d & 32'h1, 32'h1);
    check("R12 line idle", {31'b0, txd}, 32'd1);
    wr(5'h08, 32'h3F);
    repeat (200) @(negedge clk);
    rd(5'h04, d); check("R12 sent after enable", d & 32'h1, 32'h0);
    // R7 receive
    wr(5'h0C, 32'hF);
    send(8'h96);
    repeat (4) @(negedge clk);
    rd(5'h04, d); check("R7 rx full", d & 32'h2, 32'h2);
    check("R7 rx_irq", {31'b0, rx_irq}, 32'd1);
    rd(5'h00, d); check("R7 byte 96", d, 32'h96);
    rd(5'h04, d); check("R10 read clears full", d & 32'h2, 32'h0);
    wr(5'h0C, 32'h2);
    check("R11 rx_irq cleared", {31'b0, rx_irq}, 32'd0);
    // R10 receive overrun
    send(8'h5A);
    send(8'hC3);
    repeat (4) @(negedge clk);
    rd(5'h04, d); check("R10 rx overrun status", d & 32'h8, 32'h8);
    check("R10 ovr_irq rx", {31'b0, ovr_irq}, 32'd1);
    rd(5'h00, d); check("R10 first byte kept", d, 32'h5A);
    wr(5'h0C, 32'hF);
    // R8 short glitch
    @(negedge clk); rxd = 0; repeat (3) @(negedge clk); rxd = 1;
    repeat (40) @(negedge clk);
    rd(5'h04, d); check("R8 glitch ignored", d & 32'h2, 32'h0);
    check("R8 no rx_irq", {31'b0, rx_irq}, 32'd0);
    // R9 receive disabled
    wr(5'h08, 32'h3D);
    send(8'hA3);
    repeat (4) @(negedge clk);
    rd(5'h04, d); check("R9 frame ignored", d & 32'h2, 32'h0);
    wr(5'h08, 32'h3F);
    send(8'h0F);
    repeat (4) @(negedge clk);
    rd(5'h00, d); check("R7 byte 0F", d, 32'h0F);
    repeat (10) @(negedge clk);
    mon = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule